// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block predicts the next fetch address in the same cycle that the current fetch PC is presented. It holds recently taken branches in a small set-associative table. Each entry pairs a branch address tag with the target that branch last jumped to. When the fetch PC matches a valid entry, the block reports a hit and a taken prediction, and it steers fetch to the stored target. When nothing matches, it predicts fall-through to the next sequential word. Instructions are 4 bytes wide. There is no separate direction table: a hit is the taken prediction.

Resolved branches come back through an update port. A taken branch either refreshes its existing entry or is installed into its set. A not-taken branch that is present is removed, so it returns to the sequential default. Within each two-way set, a single bit tracks the least recently used way. Both fetch hits and taken resolutions refresh that bit. When an update and a lookup touch the same set in one cycle, the update governs the bit.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup whose PC matches a valid entry gives lk_hit_o=1, lk_taken_o=1 and lk_next_pc_o equal to the stored target, combinationally in the same cycle.
- R3: A lookup that matches no valid entry gives lk_hit_o=0, lk_taken_o=0 and lk_next_pc_o = lk_pc_i + 4.
- R4: The set is selected by PC bits [5:2] and the tag is PC bits [31:6]. PCs that differ only in bits [1:0] address the same entry.
- R5: A taken update that misses installs its tag and target. It goes into way 0 if way 0 is invalid, otherwise into way 1 if way 1 is invalid, otherwise into the least recently used way of the set. The installed way becomes most recently used.
- R6: A taken update that hits rewrites that entry's target in place and marks that way most recently used. A branch never occupies two ways.
- R7: A not-taken update that hits invalidates the entry and leaves the LRU bit unchanged. A not-taken update that misses changes nothing.
- R8: A lookup hit marks the hit way most recently used.
- R9: If an update is valid for the same set as the lookup in the same cycle, the lookup's LRU refresh is dropped. Only the update's effect, if any, is applied.
- R10: An update takes effect at the next clock edge. A lookup in the same cycle sees the table as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | 32 | Current fetch PC |
| lk_next_pc_o | output | 32 | Predicted next fetch PC |
| lk_taken_o | output | 1 | Predicted taken |
| lk_hit_o | output | 1 | Lookup matched a valid entry |
| upd_valid_i | input | 1 | Resolved-branch update present |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A fetch lookup and a branch resolution can land on the same set in the same cycle. Both then want to change that set's LRU bit, and the update may also change the entry the lookup is reading. A directed case first fills a set with two branches. It then looks up one of them while a not-taken update for a third branch in that set arrives, and afterwards installs the third branch. Which entry is evicted shows whether the lookup's refresh was correctly suppressed. Random traffic over a small pool of conflicting PCs repeats such collisions many times, and each cycle's prediction is compared against a bench model of the table.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned BTB_WAYS     = 2;
  localparam int unsigned BTB_RD_PORTS = 3;
  localparam int unsigned RD_LOOKUP    = 0;
  localparam int unsigned RD_UPDATE    = 1;
  localparam int unsigned RD_CHECK     = 2;
endpackage

// File: rtl/btb_way.sv
module btb_way #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned TAG_W    = 26,
  parameter int unsigned TGT_W    = 32,
  parameter int unsigned RD_PORTS = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]     rd_idx_i,
  output logic [RD_PORTS-1:0]                rd_valid_o,
  output logic [RD_PORTS-1:0][TAG_W-1:0]     rd_tag_o,
  output logic [RD_PORTS-1:0][TGT_W-1:0]     rd_tgt_o,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   wr_idx_i,
  input  logic                               wr_valid_i,
  input  logic [TAG_W-1:0]                   wr_tag_i,
  input  logic [TGT_W-1:0]                   wr_tgt_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0][TGT_W-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      tgt_q   <= '0;
    end else if (we_i) begin
      valid_q[wr_idx_i] <= wr_valid_i;
      tag_q[wr_idx_i]   <= wr_tag_i;
      tgt_q[wr_idx_i]   <= wr_tgt_i;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_valid_o[p] = valid_q[rd_idx_i[p]];
    assign rd_tag_o[p]   = tag_q[rd_idx_i[p]];
    assign rd_tgt_o[p]   = tgt_q[rd_idx_i[p]];
  end
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_en_i,
  input  logic [IDX_W-1:0]        upd_set_i,
  input  logic                    upd_way_i,
  input  logic                    lk_en_i,
  input  logic [IDX_W-1:0]        lk_set_i,
  input  logic                    lk_way_i,
  output logic [(1<<IDX_W)-1:0]   lru_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // lru_o[s] names the least recently used way of set s
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_o <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (upd_en_i && upd_set_i == IDX_W'(s))
          lru_o[s] <= ~upd_way_i;
        else if (lk_en_i && lk_set_i == IDX_W'(s))
          lru_o[s] <= ~lk_way_i;
      end
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned SET_BITS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic [PC_W-1:0] lk_next_pc_o,
  output logic            lk_taken_o,
  output logic            lk_hit_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_taken_i
);
  localparam int unsigned TAG_W = PC_W - SET_BITS - 2;
  localparam int unsigned NSETS = 1 << SET_BITS;

  logic [SET_BITS-1:0] lk_set, up_set;
  logic [TAG_W-1:0]    lk_tag, up_tag;
  assign lk_set = lk_pc_i[SET_BITS+1:2];
  assign lk_tag = lk_pc_i[PC_W-1:SET_BITS+2];
  assign up_set = upd_pc_i[SET_BITS+1:2];
  assign up_tag = upd_pc_i[PC_W-1:SET_BITS+2];

  logic unused_pc_lsb;
  assign unused_pc_lsb = ^upd_pc_i[1:0];

  // check-only capture of the previous cycle's update and LRU events
  logic                chk_v_q, chk_taken_q;
  logic [SET_BITS-1:0] chk_set_q;
  logic [TAG_W-1:0]    chk_tag_q;
  logic [PC_W-1:0]     chk_tgt_q;

  logic [BTB_RD_PORTS-1:0][SET_BITS-1:0] rd_idx;
  assign rd_idx[RD_LOOKUP] = lk_set;
  assign rd_idx[RD_UPDATE] = up_set;
  assign rd_idx[RD_CHECK]  = chk_set_q;

  logic [BTB_WAYS-1:0]            lk_match, up_match, up_vld, chk_match;
  logic [BTB_WAYS-1:0][PC_W-1:0]  lk_tgt_w;
  logic [BTB_WAYS-1:0]            we;
  logic                           wr_way, wr_valid;
  logic [NSETS-1:0]               lru;

  for (genvar w = 0; w < BTB_WAYS; w++) begin : g_way
    logic [BTB_RD_PORTS-1:0]             v;
    logic [BTB_RD_PORTS-1:0][TAG_W-1:0]  t;
    logic [BTB_RD_PORTS-1:0][PC_W-1:0]   g;

    btb_way #(
      .IDX_W(SET_BITS), .TAG_W(TAG_W), .TGT_W(PC_W), .RD_PORTS(BTB_RD_PORTS)
    ) u_way (
      .clk_i, .rst_ni,
      .rd_idx_i  (rd_idx),
      .rd_valid_o(v),
      .rd_tag_o  (t),
      .rd_tgt_o  (g),
      .we_i      (we[w]),
      .wr_idx_i  (up_set),
      .wr_valid_i(wr_valid),
      .wr_tag_i  (up_tag),
      .wr_tgt_i  (upd_target_i)
    );

    assign lk_match[w]  = v[RD_LOOKUP] && t[RD_LOOKUP] == lk_tag;
    assign lk_tgt_w[w]  = g[RD_LOOKUP];
    assign up_vld[w]    = v[RD_UPDATE];
    assign up_match[w]  = v[RD_UPDATE] && t[RD_UPDATE] == up_tag;
    assign chk_match[w] = v[RD_CHECK] && t[RD_CHECK] == chk_tag_q &&
                          (!chk_taken_q || g[RD_CHECK] == chk_tgt_q);
  end

  // lookup path
  logic lk_way;
  assign lk_hit_o     = |lk_match;
  assign lk_way       = lk_match[1];
  assign lk_taken_o   = lk_hit_o;
  assign lk_next_pc_o = lk_hit_o ? lk_tgt_w[lk_way] : lk_pc_i + PC_W'(4);

  // update path: hit way, else first invalid way, else LRU way
  logic up_hit, up_hit_way, victim;
  assign up_hit     = |up_match;
  assign up_hit_way = up_match[1];
  assign victim     = !up_vld[0] ? 1'b0 : (!up_vld[1] ? 1'b1 : lru[up_set]);
  assign wr_way     = up_hit ? up_hit_way : victim;
  assign wr_valid   = upd_taken_i;

  for (genvar w = 0; w < BTB_WAYS; w++) begin : g_we
    assign we[w] = upd_valid_i && (upd_taken_i || up_hit) && wr_way == 1'(w);
  end

  logic upd_touch, lk_touch;
  assign upd_touch = upd_valid_i && upd_taken_i;
  assign lk_touch  = lk_hit_o && !(upd_valid_i && up_set == lk_set);

  btb_lru #(.IDX_W(SET_BITS)) u_lru (
    .clk_i, .rst_ni,
    .upd_en_i (upd_touch),
    .upd_set_i(up_set),
    .upd_way_i(wr_way),
    .lk_en_i  (lk_touch),
    .lk_set_i (lk_set),
    .lk_way_i (lk_way),
    .lru_o    (lru)
  );

  logic                tq_v, tq_way, cf_v, cf_lru;
  logic [SET_BITS-1:0] tq_set, cf_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_q <= 1'b0; chk_taken_q <= 1'b0; chk_set_q <= '0;
      chk_tag_q <= '0; chk_tgt_q <= '0;
      tq_v <= 1'b0; tq_way <= 1'b0; tq_set <= '0;
      cf_v <= 1'b0; cf_lru <= 1'b0; cf_set <= '0;
    end else begin
      chk_v_q     <= upd_valid_i;
      chk_taken_q <= upd_taken_i;
      chk_set_q   <= up_set;
      chk_tag_q   <= up_tag;
      chk_tgt_q   <= upd_target_i;
      tq_v        <= lk_hit_o && !upd_valid_i;
      tq_way      <= lk_way;
      tq_set      <= lk_set;
      cf_v        <= lk_hit_o && upd_valid_i && !upd_taken_i && up_set == lk_set;
      cf_lru      <= lru[lk_set];
      cf_set      <= lk_set;
    end
  end

  // R6
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  // R5
  install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_v_q && chk_taken_q) |-> (|chk_match));

  // R7
  evict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_v_q && !chk_taken_q) |-> !(|chk_match));

  // R8
  lru_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tq_v |-> lru[tq_set] == ~tq_way);

  // R9
  lru_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cf_v |-> lru[cf_set] == cf_lru);
endmodule

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0, upd_pc = '0, upd_tgt = '0;
  logic        upd_v = 1'b0, upd_tk = 1'b0;
  logic [31:0] nxt;
  logic        tk, hit;

  always #10 clk = ~clk;

  btb_predictor dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_pc_i(lk_pc), .lk_next_pc_o(nxt), .lk_taken_o(tk), .lk_hit_o(hit),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_target_i(upd_tgt),
    .upd_taken_i(upd_tk)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model of the table
  bit          mv[16][2];
  logic [25:0] mt[16][2];
  logic [31:0] mg[16][2];
  bit          ml[16];

  function automatic void m_find(input logic [31:0] pc, output bit h, output bit w);
    int s = int'(pc[5:2]);
    h = 0; w = 0;
    for (int i = 0; i < 2; i++)
      if (mv[s][i] && mt[s][i] == pc[31:6]) begin h = 1; w = i[0]; end
  endfunction

  task automatic m_clock();
    bit lh, lw, uh, uw, vw;
    int ls = int'(lk_pc[5:2]);
    int us = int'(upd_pc[5:2]);
    m_find(lk_pc, lh, lw);
    m_find(upd_pc, uh, uw);
    if (upd_v && upd_tk) begin
      vw = uh ? uw : (!mv[us][0] ? 1'b0 : (!mv[us][1] ? 1'b1 : ml[us]));
      mv[us][vw] = 1; mt[us][vw] = upd_pc[31:6]; mg[us][vw] = upd_tgt;
      ml[us] = ~vw;
    end else if (upd_v && uh) begin
      mv[us][uw] = 0;
    end
    if (lh && !(upd_v && us == ls)) ml[ls] = ~lw;
  endtask

  task automatic step(input logic [31:0] lpc, input bit uv, input logic [31:0] upc,
                      input logic [31:0] ut, input bit utk, input string req);
    bit eh, ew;
    logic [31:0] en;
    @(negedge clk);
    lk_pc = lpc; upd_v = uv; upd_pc = upc; upd_tgt = ut; upd_tk = utk;
    #1;
    m_find(lpc, eh, ew);
    en = eh ? mg[lpc[5:2]][ew] : lpc + 32'd4;
    checks++;
    if (hit !== eh || tk !== eh || nxt !== en) begin
      fails++;
      $display("FAIL %s pc=%h: hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
               req, lpc, hit, tk, nxt, eh, eh, en);
    end
    @(posedge clk);
    m_clock();
  endtask

  localparam logic [31:0] IDLE = 32'h0000_0F3C; // set 15, never installed
  localparam logic [31:0] A = 32'h0000_1004, B = 32'h0000_1044, C = 32'h0000_1084;
  localparam logic [31:0] E = 32'h0000_2008, F = 32'h0000_2048, G = 32'h0000_2088;

  function automatic logic [31:0] pool_pc();
    logic [31:0] p;
    p = {24'h000_0A0 + 24'($urandom_range(0, 2)), 2'b00, 4'($urandom_range(0, 3)), 2'b00};
    p[1:0] = 2'($urandom_range(0, 3));
    return p;
  endfunction

  initial begin
    void'($urandom(32'd470));
    for (int s = 0; s < 16; s++) begin
      ml[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 0; mt[s][w] = '0; mg[s][w] = '0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state, R3 sequential fall-through
    step(32'h0000_0100, 0, 0, 0, 0, "R1");
    step(A, 0, 0, 0, 0, "R3");
    // R10 update invisible in its own cycle
    step(A, 1, A, 32'h0000_2000, 1, "R10");
    // R2 hit, R5 allocate into way 0
    step(A, 0, 0, 0, 0, "R2");
    step(A | 32'h3, 0, 0, 0, 0, "R4");
    step(IDLE, 1, B, 32'h0000_3000, 1, "R5");
    step(B, 0, 0, 0, 0, "R5");
    // R9 same-set lookup and not-taken update; then C evicts LRU
    step(A, 1, C, 32'h0000_4000, 0, "R9");
    step(IDLE, 1, C, 32'h0000_4000, 1, "R9");
    step(A, 0, 0, 0, 0, "R9");
    step(C, 0, 0, 0, 0, "R9");
    // R6 target refresh on hit
    step(IDLE, 1, B, 32'h0000_5000, 1, "R6");
    step(B, 0, 0, 0, 0, "R6");
    // R7 not-taken hit invalidates, not-taken miss is harmless
    step(IDLE, 1, B, 0, 0, "R7");
    step(B, 1, A, 0, 0, "R7");
    step(C, 0, 0, 0, 0, "R7");
    // R8 lookup hit refreshes LRU
    step(IDLE, 1, E, 32'h0000_6000, 1, "R8");
    step(IDLE, 1, F, 32'h0000_7000, 1, "R8");
    step(E, 0, 0, 0, 0, "R8");
    step(IDLE, 1, G, 32'h0000_8000, 1, "R8");
    step(E, 0, 0, 0, 0, "R8");
    step(F, 0, 0, 0, 0, "R8");
    step(G, 0, 0, 0, 0, "R8");
    // random mix over conflicting pool, R4 low bits randomized
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] lp, up;
      lp = pool_pc(); up = pool_pc();
      step(lp, $urandom_range(0, 1) == 1, up, {$urandom() & 32'hFFFF_FFFC},
           $urandom_range(0, 9) < 7, "R2/R3 random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule